// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block keeps a 16-bit up-counter that advances once every 1, 4, 8 or 16 bus-clock cycles. Software reaches it through a small byte-wide register port. Two addresses expose the counter as a high byte and a low byte, and either byte can be loaded. A third address holds a mask register. That register carries the prescale select and the overflow interrupt enable. A fourth address is a status register that holds the overflow flag.

The divide ratio can only be chosen early. The prescale field takes new values only during the first 64 clock edges after reset. After that, writes to the mask register still update its other bits, but the prescale bits keep their old value. Loading a counter byte restarts the prescale divider, so the next increment comes exactly one prescale period after the load. When the counter wraps from 0xFFFF to 0x0000 the overflow flag is set. Software clears the flag by writing one to it. The flag, gated by its enable, drives an interrupt request. The live count is also brought out on a port so that compare and capture logic can use it.

Top module: `ptmr_top`

## Requirements
- R1: While reset is asserted, the counter, mask register, status register and interrupt output are all zero.
- R2: Mask bits [1:0] select the increment period: code 0 gives 1 cycle, code 1 gives 4, code 2 gives 8 and code 3 gives 16. The counter rises by exactly one per period, and at no other time except a load.
- R3: A mask write on clock edges 1 to 64 after reset release updates all eight bits. A mask write on any later edge updates bits [7:2] and leaves bits [1:0] unchanged.
- R4: A mask write that is accepted inside the window clears the prescale divider. The first increment after it then falls a full new period after that write edge.
- R5: Reads are combinational on `reg_addr`. Address 0 returns count[15:8], address 1 returns count[7:0] and address 2 returns the mask register. Address 3 returns status, with the overflow flag in bit 7 and zeros in bits [6:0].
- R6: A write to address 0 replaces count[15:8], and a write to address 1 replaces count[7:0]. The other byte keeps its current value, and any increment due on that edge is dropped. The divider is cleared, so the next increment comes one full period after the write edge.
- R7: The overflow flag (status bit 7) is set on the same edge on which an increment takes the counter from 0xFFFF to 0x0000. A load of 0x0000 does not set it.
- R8: Writing status with bit 7 = 1 clears the flag, and writing bit 7 = 0 leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag stays set.
- R9: `irq_o` is high exactly when the overflow flag is set and mask bit 7 is one.
- R10: `count_o` always equals the value returned by the two counter byte reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 count high, 1 count low, 2 mask, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| count_o | output | 16 | Live counter value |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The divider phase cannot be seen directly. A wrong phase shows up as a counter value that is off by one at a period boundary, within at most 16 cycles of the last load or accepted prescale change. The bench therefore samples one edge before and one edge after each boundary. A broken lock window shows in the mask readback on the cycle after the offending write. A wrong flag or gating shows on the status read and on `irq_o` one edge after the wrap or the write.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
   localparam int BYTE_W       = 8;
   localparam int ADDR_W       = 2;
   localparam int IRQ_EN_BIT   = 7;
   localparam int OVF_FLAG_BIT = 7;
   localparam int PS_FIELD_W   = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CNT_HI = 2'd0,
      SEL_CNT_LO = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_STAT   = 2'd3
   } reg_sel_e;

   // prescale code -> log2 of division ratio
   function automatic int unsigned ps_shift(input logic [PS_FIELD_W-1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 2;
         2'd2:    return 3;
         default: return 4;
      endcase
   endfunction

   localparam int MAX_SHIFT = 4;
endpackage

// File: rtl/ptmr_lock_window.sv
`timescale 1ns/1ps
module ptmr_lock_window #(
   parameter int LOCK_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic open_o
);
   localparam int LW = $clog2(LOCK_CYCLES + 1);

   logic [LW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '0;
      else if (age_q != LW'(LOCK_CYCLES))
         age_q <= age_q + 1'b1;
   end

   assign open_o = (age_q < LW'(LOCK_CYCLES));
endmodule

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
   parameter int DIV_W = 4,
   parameter int SH_W  = $clog2(DIV_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic [SH_W-1:0] shift_i,
   output logic            tick_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] sel_mask;

   always_comb sel_mask = ~({DIV_W{1'b1}} << shift_i);

   // tick when every selected low bit is one; the divider wraps on its own
   assign tick_o = &(div_q | ~sel_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (clear_i)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
module ptmr_counter #(
   parameter int NUM_BYTES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_i,
   input  logic [NUM_BYTES-1:0]   lane_wr_i,
   input  logic [7:0]             wdata_i,
   output logic [NUM_BYTES*8-1:0] count_o,
   output logic                   wrap_o
);
   localparam int CW = NUM_BYTES * 8;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] merged;
   logic          any_wr;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = lane_wr_i[b] ? wdata_i : cnt_q[b*8 +: 8];
   end

   assign any_wr = |lane_wr_i;
   assign wrap_o = tick_i && !any_wr && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (any_wr)
         cnt_q <= merged;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/ptmr_top.sv
`timescale 1ns/1ps
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int LOCK_CYCLES = 64,
   parameter int CNT_BYTES   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [1:0]             reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   output logic [CNT_BYTES*8-1:0] count_o,
   output logic                   irq_o
);
   localparam int CW    = CNT_BYTES * BYTE_W;
   localparam int DIV_W = MAX_SHIFT;
   localparam int SH_W  = $clog2(DIV_W + 1);

   if (CNT_BYTES != 2) begin : g_bad_bytes
      $error("ptmr_top: the register map addresses exactly two counter bytes");
   end
   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("ptmr_top: LOCK_CYCLES must be positive");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic wr_hi, wr_lo, wr_mask, wr_stat;
   assign wr_hi   = reg_wr && (sel == SEL_CNT_HI);
   assign wr_lo   = reg_wr && (sel == SEL_CNT_LO);
   assign wr_mask = reg_wr && (sel == SEL_MASK);
   assign wr_stat = reg_wr && (sel == SEL_STAT);

   logic            window_open;
   logic [7:0]      mask_q;
   logic            ovf_flag_q;
   logic            tick, wrap, ps_clear;
   logic [SH_W-1:0] shift;

   ptmr_lock_window #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .open_o (window_open)
   );

   assign shift    = SH_W'(ps_shift(mask_q[PS_FIELD_W-1:0]));
   assign ps_clear = (wr_mask && window_open) || wr_hi || wr_lo;

   ptmr_prescaler #(.DIV_W(DIV_W), .SH_W(SH_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (ps_clear),
      .shift_i (shift),
      .tick_o  (tick)
   );

   ptmr_counter #(.NUM_BYTES(CNT_BYTES)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .lane_wr_i ({wr_hi, wr_lo}),
      .wdata_i   (reg_wdata),
      .count_o   (count_o),
      .wrap_o    (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_mask) begin
         if (window_open)
            mask_q <= reg_wdata;
         else
            mask_q <= {reg_wdata[7:PS_FIELD_W], mask_q[PS_FIELD_W-1:0]};
      end
   end

   // set has priority over a clearing write on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_flag_q <= 1'b0;
      else if (wrap)
         ovf_flag_q <= 1'b1;
      else if (wr_stat && reg_wdata[OVF_FLAG_BIT])
         ovf_flag_q <= 1'b0;
   end

   assign irq_o = ovf_flag_q && mask_q[IRQ_EN_BIT];

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_CNT_HI: reg_rdata = count_o[CW-1:BYTE_W];
         SEL_CNT_LO: reg_rdata = count_o[BYTE_W-1:0];
         SEL_MASK:   reg_rdata = mask_q;
         default:    reg_rdata[OVF_FLAG_BIT] = ovf_flag_q;
      endcase
   end
endmodule

// File: rtl/ptmr_top_chk.sv
`timescale 1ns/1ps
module ptmr_top_chk #(
   parameter int LOCK_CYCLES = 64,
   parameter int CW          = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [1:0]    reg_addr,
   input logic [7:0]    reg_wdata,
   input logic [CW-1:0] count_o,
   input logic          irq_o,
   input logic          flag,
   input logic [7:0]    mask
);
   localparam int LW = $clog2(LOCK_CYCLES + 1);

   logic [LW-1:0] edges_q;
   logic          locked;
   logic          cnt_wr, hi_wr, clr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         edges_q <= '0;
      else if (edges_q != LW'(LOCK_CYCLES))
         edges_q <= edges_q + 1'b1;
   end

   assign locked = (edges_q == LW'(LOCK_CYCLES));
   assign hi_wr  = reg_wr && (reg_addr == 2'd0);
   assign cnt_wr = reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd1);
   assign clr_wr = reg_wr && (reg_addr == 2'd3) && reg_wdata[7];

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_wr) && count_o != $past(count_o)) |-> count_o == $past(count_o) + 1'b1);

   // R3
   prescale_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> mask[1:0] == $past(mask[1:0]));

   // R6
   high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hi_wr) |-> (count_o[CW-1:8] == $past(reg_wdata)) && (count_o[7:0] == $past(count_o[7:0])));

   // R7
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(&count_o) && count_o == '0 && !$past(cnt_wr)) |-> flag);

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr_wr));

   // R9
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> !irq_o);

   // R9
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask[7] |-> !irq_o);
endmodule

bind ptmr_top ptmr_top_chk #(.LOCK_CYCLES(LOCK_CYCLES), .CW(CNT_BYTES*8)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .count_o   (count_o),
   .irq_o     (irq_o),
   .flag      (ovf_flag_q),
   .mask      (mask_q)
);

// File: tb/ptmr_top_test.sv
`timescale 1ns/1ps
module ptmr_top_test;
   localparam int CLK_P = 10;
   localparam int NVEC  = 10;

   // {code[1:0], start[15:0], waits[7:0], expected[15:0], flag}
   localparam logic [42:0] VEC [NVEC] = '{
      {2'd0, 16'h1234, 8'd5,  16'h1239, 1'b0},
      {2'd1, 16'h00FF, 8'd9,  16'h0101, 1'b0},
      {2'd2, 16'hABCD, 8'd7,  16'hABCD, 1'b0},
      {2'd2, 16'hABCD, 8'd8,  16'hABCE, 1'b0},
      {2'd3, 16'h0010, 8'd15, 16'h0010, 1'b0},
      {2'd3, 16'h0010, 8'd16, 16'h0011, 1'b0},
      {2'd3, 16'h0010, 8'd40, 16'h0012, 1'b0},
      {2'd1, 16'hFFFF, 8'd4,  16'h0000, 1'b1},
      {2'd1, 16'hFFFF, 8'd3,  16'hFFFF, 1'b0},
      {2'd0, 16'hFFFE, 8'd1,  16'hFFFF, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic [15:0] count_o;
   logic        irq_o;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   ptmr_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .count_o   (count_o),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #(CLK_P*2);
      @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P*150000);
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 16'd1, 16'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      // R1: reset state
      #(CLK_P*3);
      chk("R1 count", count_o, 16'h0000);
      rd(2'd2, d); chk("R1 mask", {8'd0, d}, 16'h0000);
      rd(2'd3, d); chk("R1 status", {8'd0, d}, 16'h0000);
      chk("R1 irq", {15'd0, irq_o}, 16'h0000);

      // R2 R5 R7 R10: table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  code;
         logic [15:0] start, expv;
         logic [7:0]  waits;
         logic        expf;
         {code, start, waits, expv, expf} = VEC[i];
         do_reset();
         wr(2'd2, {6'd0, code});
         wr(2'd0, start[15:8]);
         wr(2'd1, start[7:0]);
         repeat (waits) @(posedge clk);
         #1;
         chk("R2 count", count_o, expv);
         rd(2'd0, d); chk("R5 high byte", {8'd0, d}, {8'd0, expv[15:8]});
         rd(2'd1, d); chk("R10 low byte", {8'd0, d}, {8'd0, expv[7:0]});
         rd(2'd3, d); chk("R7 flag", {8'd0, d}, {8'd0, expf, 7'd0});
      end

      // R4: accepted prescale change clears the divider
      do_reset();
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h02);
      chk("R4 after mask write", count_o, 16'h0001);
      repeat (7) @(posedge clk); #1;
      chk("R4 before boundary", count_o, 16'h0001);
      @(posedge clk); #1;
      chk("R4 at boundary", count_o, 16'h0002);

      // R3: last accepted edge (64)
      do_reset();
      repeat (63) @(posedge clk); #1;
      wr(2'd2, 8'h03);
      rd(2'd2, d); chk("R3 edge 64 accepted", {8'd0, d}, 16'h0003);

      // R3: first locked edge (65)
      do_reset();
      repeat (64) @(posedge clk); #1;
      wr(2'd2, 8'h03);
      rd(2'd2, d); chk("R3 edge 65 locked", {8'd0, d}, 16'h0000);
      wr(2'd2, 8'hFD);
      rd(2'd2, d); chk("R3 upper bits update", {8'd0, d}, 16'h00FC);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h10);
      repeat (3) @(posedge clk); #1;
      chk("R3 ratio unchanged", count_o, 16'h0013);

      // R6: byte loads keep the other byte
      wr(2'd1, 8'h34);
      wr(2'd0, 8'h56);
      chk("R6 high load", count_o, 16'h5634);
      @(posedge clk); #1;
      chk("R6 next increment", count_o, 16'h5635);

      // R8 R9: set beats clear; gating; clear rules
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hFF);
      wr(2'd3, 8'h80);
      rd(2'd3, d); chk("R8 set wins", {8'd0, d}, 16'h0080);
      chk("R9 irq enabled", {15'd0, irq_o}, 16'h0001);
      wr(2'd2, 8'h7C);
      chk("R9 irq masked", {15'd0, irq_o}, 16'h0000);
      wr(2'd3, 8'h7F);
      rd(2'd3, d); chk("R8 zero keeps flag", {8'd0, d}, 16'h0080);
      wr(2'd2, 8'hFC);
      chk("R9 irq re-enabled", {15'd0, irq_o}, 16'h0001);
      wr(2'd3, 8'h80);
      rd(2'd3, d); chk("R8 one clears", {8'd0, d}, 16'h0000);
      chk("R9 irq after clear", {15'd0, irq_o}, 16'h0000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule